// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a two-wire bus slave in front of a 512-byte on-chip memory. The open-drain clock and data lines arrive as plain inputs. The slave pulls the data line low by raising a single output-enable signal, which the pad logic turns into an open-drain driver. Both lines are brought into the system clock domain through a short synchroniser. Edges, start conditions and stop conditions are all detected on the synchronised copies. The system clock must run at least eight times faster than the bus clock.

A bus master addresses the slave with a device byte. That byte carries a 4-bit device-type code, a page bit and a direction bit. The page bit becomes bit 8 of the memory address. An 8-bit address latch supplies bits 7:0, and the latch keeps its value from one transaction to the next. A write transaction loads the latch from a word-address byte and then stores any number of data bytes. A read transaction starts at the location just after the last one accessed and continues for as long as the master acknowledges. A selective read is a write that is cut short by a repeated start right after the word address, followed by a read.

Top module: `i2c_mem_slave`

## Requirements
- R1: A falling data line while the clock is high is a start. It clears the bit count, releases the data line and makes the slave expect a device byte, even in the middle of a byte. A rising data line while the clock is high is a stop. It releases the data line and idles the slave.
- R2: The slave answers only when bits 7:4 of the device byte equal the device-type parameter (default 4'b1010). On a mismatch it never acknowledges and stays released until the next start.
- R3: The slave acknowledges a matching device byte, a word-address byte and every written data byte by holding the data line low for the ninth clock. It changes the data line only while the clock is low, and it drives nothing outside its acknowledge and read-data bit times.
- R4: Bit 0 of the device byte gives the direction (1 = read, 0 = write). Bit 1 is the page bit and becomes address bit 8 for the transaction.
- R5: In a write, the byte after the device byte loads address bits 7:0. Each following data byte is stored at the current 9-bit address, and the address then increments.
- R6: A read begins at the current address, which is the location after the last byte written or read. Data is sent MSB first.
- R7: Each read byte advances the address. While the master acknowledges (data low in the ninth clock), the slave sends the next sequential byte.
- R8: Incrementing from address 0x1FF gives 0x000, for reads and for writes.
- R9: A no-acknowledge from the master ends a read. The slave keeps the data line released through any further clocks until a start or a stop.
- R10: A repeated start right after the acknowledged word address aborts the write without storing anything. A following read device byte then reads from the loaded address.
- R11: Start and stop conditions leave the address latch unchanged.
- R12: A stop issued in place of the master's ninth-clock acknowledge ends a read. The next read continues from the following address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_oe | output | 1 | 1 = pull the data line low, 0 = release it |

## Verification
Four properties are checked on every cycle. The output enable only rises while the raw clock is low. Every start and every stop releases the line on the next cycle. Start and stop leave the address latch alone. A memory write only ever follows a synchronised falling clock edge. Other behaviours can only be shown by the bench's scenarios against its reference memory model: device-code matching, page selection, sequential reads, wrap from 0x1FF to 0x000, aborted writes, the three read-termination forms, and the carry-over of the latch between transactions. The bench also checks on every clock that the slave never drives outside the windows its model allows.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int BYTE_W   = 8;
  localparam int ID_W     = 4;
  localparam int PAGE_POS = 1;
  localparam int RW_POS   = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_HOLD
  } slv_state_t;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] line_s;
  logic [LINES-1:0] line_q;

  assign raw = {sda_i, scl_i};

  // one synchroniser chain per bus line, idle-high after reset
  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-2:0], raw[g]};
      end
      assign line_s[g] = sr[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) line_q <= '1;
    else     line_q <= line_s;
  end

  assign sda_s     = line_s[1];
  assign scl_rise  =  line_s[0] & ~line_q[0];
  assign scl_fall  = ~line_s[0] &  line_q[0];
  assign start_det =  line_s[0] & line_q[0] &  line_q[1] & ~line_s[1];
  assign stop_det  =  line_s[0] & line_q[0] & ~line_q[1] &  line_s[1];
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_mem_pkg::*;
#(
  parameter logic [ID_W-1:0] DEV_ID = 4'b1010,
  parameter int              AW     = BYTE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [AW-1:0]     cur_addr,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam int                 CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0]   CNT_FULL = CNT_W'(BYTE_W);
  localparam int                 ID_HI    = BYTE_W - 1;
  localparam int                 ID_LO    = BYTE_W - ID_W;

  slv_state_t        state, after_ack;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] tx;
  logic [AW-1:0]     addr_q;
  logic              oe_q;
  logic              m_ack;

  assign cur_addr = addr_q;
  assign sda_oe   = oe_q;

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      state     <= ST_IDLE;
      after_ack <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      tx        <= '0;
      addr_q    <= '0;
      oe_q      <= 1'b0;
      m_ack     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else if (start_det) begin
      state   <= ST_DEV;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_WORD, ST_WDATA: begin
          if (scl_rise) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == CNT_FULL) begin
            bit_cnt <= '0;
            if (state == ST_DEV) begin
              if (shreg[ID_HI:ID_LO] == DEV_ID) begin
                addr_q[AW-1] <= shreg[PAGE_POS];
                after_ack    <= shreg[RW_POS] ? ST_RDATA : ST_WORD;
                oe_q         <= 1'b1;
                state        <= ST_ACK;
              end else begin
                state <= ST_HOLD;
              end
            end else if (state == ST_WORD) begin
              addr_q[BYTE_W-1:0] <= shreg;
              after_ack          <= ST_WDATA;
              oe_q               <= 1'b1;
              state              <= ST_ACK;
            end else begin
              wr_en     <= 1'b1;
              wr_addr   <= addr_q;
              wr_data   <= shreg;
              addr_q    <= addr_q + 1'b1;
              after_ack <= ST_WDATA;
              oe_q      <= 1'b1;
              state     <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (after_ack == ST_RDATA) begin
              tx      <= rd_data;
              oe_q    <= ~rd_data[BYTE_W-1];
              addr_q  <= addr_q + 1'b1;
              bit_cnt <= CNT_W'(1);
              state   <= ST_RDATA;
            end else begin
              oe_q    <= 1'b0;
              bit_cnt <= '0;
              state   <= after_ack;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_cnt == CNT_FULL) begin
              oe_q    <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_RACK;
            end else begin
              oe_q    <= ~tx[BYTE_W-2];
              tx      <= {tx[BYTE_W-2:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (m_ack) begin
              tx      <= rd_data;
              oe_q    <= ~rd_data[BYTE_W-1];
              addr_q  <= addr_q + 1'b1;
              bit_cnt <= CNT_W'(1);
              state   <= ST_RDATA;
            end else begin
              state <= ST_HOLD;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter logic [ID_W-1:0] DEV_ID      = 4'b1010,
  parameter int              SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int ADDR_W = BYTE_W + 1;

  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] cur_addr, wr_addr;
  logic [BYTE_W-1:0] rd_data, wr_data;
  logic              mem_we;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_slave_ctrl #(.DEV_ID(DEV_ID), .AW(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .rd_data   (rd_data),
    .cur_addr  (cur_addr),
    .wr_en     (mem_we),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  i2c_mem_array #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (cur_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          start_det,
  input logic          stop_det,
  input logic          scl_fall,
  input logic          mem_we,
  input logic [AW-1:0] cur_addr
);
  // R3
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  // R1
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R11
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (start_det || stop_det) |=> $stable(cur_addr));

  // R5
  write_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(scl_fall));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.AW(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .start_det (start_det),
  .stop_det  (stop_det),
  .scl_fall  (scl_fall),
  .mem_we    (mem_we),
  .cur_addr  (cur_addr)
);

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int tests = 0, fails = 0, viol = 0;
  bit may_drive = 1'b0;
  int model_mem [512];
  int model_addr = 0;

  always #10 clk = ~clk;

  i2c_mem_slave u_dut (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_m),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  // per-clock comparison with the model's drive windows (R3)
  always @(negedge clk) begin
    if (!rst && !may_drive && sda_oe === 1'b1) begin
      viol++;
      if (viol <= 5) $display("FAIL R3: sda_oe actual 1 expected 0 outside slave window at %0t", $time);
    end
  end

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    wt(2); sda_m = 1'b1; wt(8); scl_m = 1'b1; wt(8); sda_m = 1'b0; wt(8); scl_m = 1'b0;
  endtask

  task automatic stop_c();
    wt(2); sda_m = 1'b0; wt(8); scl_m = 1'b1; wt(8); sda_m = 1'b1; wt(8);
  endtask

  task automatic send_bit(input logic b);
    wt(2); sda_m = b; wt(8); scl_m = 1'b1; wt(8); scl_m = 1'b0;
  endtask

  task automatic recv_bit(output logic v);
    wt(2); sda_m = 1'b1; wt(8); scl_m = 1'b1; wt(4); v = sda_line; wt(4); scl_m = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, input bit keep, output bit ack);
    logic v;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    may_drive = 1'b1;
    recv_bit(v);
    ack = (v == 1'b0);
    if (!keep) begin wt(6); may_drive = 1'b0; end
  endtask

  task automatic read_byte(output logic [7:0] b);
    logic v;
    may_drive = 1'b1;
    for (int i = 7; i >= 0; i--) begin recv_bit(v); b[i] = v; end
    wt(6);
    may_drive = 1'b0;
  endtask

  function automatic logic [7:0] dev(input int page, input bit rd);
    return {4'b1010, 2'b00, page[0], rd};
  endfunction

  task automatic do_write(input int page, input int word, input logic [7:0] data [$], input string req);
    bit ack;
    write_byte(dev(page, 1'b0), 1'b0, ack); check({req, " device ack"}, ack, 1);
    write_byte(word[7:0], 1'b0, ack);       check({req, " word ack"}, ack, 1);
    model_addr = page * 256 + word;
    foreach (data[i]) begin
      write_byte(data[i], 1'b0, ack);       check({req, " data ack"}, ack, 1);
      model_mem[model_addr] = data[i];
      model_addr = (model_addr + 1) % 512;
    end
  endtask

  task automatic set_addr(input int page, input int word, input string req);
    bit ack;
    start_c();
    write_byte(dev(page, 1'b0), 1'b0, ack); check({req, " device ack"}, ack, 1);
    write_byte(word[7:0], 1'b0, ack);       check({req, " word ack"}, ack, 1);
    model_addr = page * 256 + word;
  endtask

  // reads n bytes; last one is not acknowledged unless last_ack
  task automatic cur_read(input int page, input int n, input bit last_ack, input string req);
    bit ack;
    logic [7:0] b;
    start_c();
    write_byte(dev(page, 1'b1), 1'b1, ack); check({req, " read device ack"}, ack, 1);
    model_addr = page * 256 + (model_addr % 256);
    for (int i = 0; i < n; i++) begin
      read_byte(b);
      check({req, " read data"}, b, model_mem[model_addr]);
      model_addr = (model_addr + 1) % 512;
      if (i < n - 1 || last_ack) send_bit(1'b0);
      else                       send_bit(1'b1);
    end
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    logic v;
    foreach (model_mem[i]) model_mem[i] = -1;
    wt(5);
    check("R1 reset release", sda_oe, 0);
    rst = 1'b0;
    wt(10);
    check("R1 idle release", sda_oe, 0);

    // R1: start in the middle of a byte restarts reception; R5 multi-byte write
    start_c();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    start_c();
    do_write(0, 8'h10, '{8'h11, 8'h22, 8'h33, 8'h44}, "R1 R5");
    stop_c();

    // R10 selective read, R7 sequential, R9 no-ack termination
    set_addr(0, 8'h10, "R10");
    cur_read(0, 3, 1'b0, "R10 R7");
    may_drive = 1'b0;
    for (int i = 7; i >= 0; i--) begin recv_bit(v); b[i] = v; end
    check("R9 released after no-ack", b, 8'hFF);
    stop_c();

    // R6 R11: current read after stop continues from next address
    cur_read(0, 1, 1'b0, "R6 R11");
    stop_c();

    // R4 page select
    start_c();
    do_write(1, 8'h10, '{8'h77}, "R4");
    stop_c();
    set_addr(1, 8'h10, "R4");
    cur_read(1, 1, 1'b0, "R4 page1");
    stop_c();
    set_addr(0, 8'h10, "R4");
    cur_read(0, 1, 1'b0, "R4 page0");
    stop_c();

    // R8 wrap 0x1FF -> 0x000 on write and read
    start_c();
    do_write(1, 8'hFE, '{8'hE1, 8'hE2, 8'hE3}, "R8");
    stop_c();
    set_addr(1, 8'hFE, "R8");
    cur_read(1, 3, 1'b0, "R8 wrap");
    stop_c();
    set_addr(0, 8'h00, "R8");
    cur_read(0, 1, 1'b0, "R8 low");
    stop_c();

    // R12 stop in the ninth clock
    set_addr(0, 8'h10, "R12");
    start_c();
    write_byte(dev(0, 1'b1), 1'b1, ack); check("R12 read device ack", ack, 1);
    read_byte(b);
    check("R12 read data", b, 8'h11);
    stop_c();
    model_addr = 16'h011;
    cur_read(0, 1, 1'b0, "R12 next");
    stop_c();

    // R2 device code mismatch, latch untouched
    start_c();
    may_drive = 1'b0;
    for (int i = 7; i >= 0; i--) send_bit(b[i] & 1'b0 | ((8'hE0 >> i) & 1));
    recv_bit(v);
    check("R2 no ack on mismatch", v, 1);
    for (int i = 7; i >= 0; i--) send_bit(1'b0);
    recv_bit(v);
    check("R2 silent until start", v, 1);
    stop_c();
    cur_read(0, 1, 1'b0, "R2 R11 latch kept");
    stop_c();

    wt(20);
    check("R3 drive windows", viol, 0);
    report();
  end
endmodule